// File: doc/BRIEF.md
# Proportional Frequency Lock Controller

This block holds an oscillator on frequency once a measured count of its output is delivered each measurement cycle. A push-button input, filtered for contact bounce, toggles between a free-running state and a lock state. After entering lock the block waits a fixed settling time and then takes the next count that arrives as its reference. Each count after that is compared with the reference. The block then issues one correction pulse on an up or a down output, and the pulse length grows with the size of the error.

The error is quantised in steps of a fixed number of count units. Every pulse has a minimum length, and each whole step adds a fixed number of cycles. A saturating error level from 0 to 9 and the direction of the latest pulse are provided for a display. While free running, during the settling wait and until the reference is taken, the block drives a neutral output that asks the external integrator for centre tuning and issues no correction. A count that arrives during a pulse is held and evaluated after the pulse ends. A button press during a pulse takes effect only after the pulse ends.

Top module: `freq_lock_ctrl`

## Requirements
- R1: After reset `locked_o`=0, `center_o`=1, `up_o`=0, `down_o`=0, `err_lvl_o`=0 and `dir_up_o`=0.
- R2: The button is resynchronised by two flops. A rising edge counts as a press only after the synchronised level has differed from the filtered level for DEB_CYC consecutive cycles. Each press toggles `locked_o`, and shorter glitches are ignored.
- R3: After a press that enters lock, counts that arrive during the next LOCK_DLY_CYC cycles are ignored and `center_o` stays 1. The first count after that wait becomes the reference, and `center_o` falls one cycle after it is taken.
- R4: A count below the reference gives a pulse on `up_o`, and a count above it gives a pulse on `down_o`. A count equal to the reference gives no pulse, sets `err_lvl_o` to 0 and leaves `dir_up_o` unchanged.
- R5: A pulse lasts MIN_W + L*STEP_W cycles, where L is the saturated error level.
- R6: `err_lvl_o` = min(floor(|count-reference|/STEP), 9). It is updated in the cycle the pulse starts.
- R7: `dir_up_o` is 1 if the latest pulse went up and 0 if it went down.
- R8: Whenever `center_o` is 1, `up_o` and `down_o` are 0. `center_o` is 0 only in tracking lock.
- R9: Each evaluated count gives at most one pulse, and a new pulse begins only after at least one idle cycle. A count that arrives during a pulse is held, with a later one replacing it, and is evaluated when the pulse ends.
- R10: A press during a pulse is deferred until the pulse has ended, and the pulse is never cut short.
- R11: Leaving lock clears `err_lvl_o` to 0 and discards any held count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| btn_i | input | 1 | Raw lock/unlock button, active high |
| count_i | input | CNT_W | Measured frequency count |
| count_vld_i | input | 1 | One-cycle strobe: `count_i` holds a new result |
| locked_o | output | 1 | Lock state entered (wait, arm or tracking) |
| center_o | output | 1 | Neutral, centre-tune command |
| up_o | output | 1 | Upward correction pulse |
| down_o | output | 1 | Downward correction pulse |
| err_lvl_o | output | 4 | Saturated error level 0..9 |
| dir_up_o | output | 1 | Direction of the latest pulse, 1 = up |

## Verification
Counts are sent equal to the reference, slightly below it, a few steps above it and far beyond saturation. This separates the no-pulse case, the minimum-width case, proportional widening and level clamping. A burst of two counts during a long pulse shows that only the later one is kept and that it is evaluated after a gap. A press during a pulse shows that an unlock waits for the pulse to finish. A short button glitch and counts sent during the settling wait show that the filter and the settling window ignore them.

// File: rtl/freq_lock_pkg.sv
`timescale 1ns/1ps
package freq_lock_pkg;
  localparam int unsigned LVL_W   = 4;
  localparam int unsigned LVL_SAT = 9;

  typedef enum logic [1:0] {
    ST_FREE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_ARM   = 2'd2,
    ST_TRACK = 2'd3
  } lock_st_e;
endpackage

// File: rtl/btn_filter.sv
`timescale 1ns/1ps
module btn_filter #(
  parameter int unsigned DEB_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic rise_o
);
  localparam int unsigned DW = $clog2(DEB_CYC + 1);

  logic          s1_q, s2_q, stab_q;
  logic [DW-1:0] cnt_q;
  logic          done;

  assign done   = (s2_q != stab_q) && (cnt_q == DW'(DEB_CYC - 1));
  assign rise_o = done && s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      stab_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
      if (s2_q == stab_q) begin
        cnt_q <= '0;
      end else if (done) begin
        stab_q <= s2_q;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lock_seq.sv
`timescale 1ns/1ps
module lock_seq
  import freq_lock_pkg::*;
#(
  parameter int unsigned CNT_W        = 24,
  parameter int unsigned LOCK_DLY_CYC = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             press_i,
  input  logic             busy_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             count_vld_i,
  output lock_st_e         st_o,
  output logic             go_o,
  output logic             drop_o,
  output logic [CNT_W-1:0] val_o,
  output logic [CNT_W-1:0] ref_o
);
  localparam int unsigned DLW = $clog2(LOCK_DLY_CYC + 1);

  lock_st_e         st_q;
  logic [DLW-1:0]   dly_q;
  logic             pend_q;
  logic             hold_vld_q;
  logic [CNT_W-1:0] hold_q, ref_q;
  logic             press_evt, tog;

  assign press_evt = press_i || pend_q;
  assign tog       = press_evt && !busy_i;   // presses wait for pulse end
  assign drop_o    = tog && (st_q != ST_FREE);
  assign go_o      = (st_q == ST_TRACK) && !busy_i && !press_evt &&
                     (hold_vld_q || count_vld_i);
  assign val_o     = hold_vld_q ? hold_q : count_i;
  assign ref_o     = ref_q;
  assign st_o      = st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
    end else if (press_evt && busy_i) begin
      pend_q <= 1'b1;
    end else if (tog) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_FREE;
      dly_q <= '0;
      ref_q <= '0;
    end else if (tog) begin
      if (st_q == ST_FREE) begin
        st_q  <= ST_WAIT;
        dly_q <= '0;
      end else begin
        st_q <= ST_FREE;
      end
    end else begin
      unique case (st_q)
        ST_WAIT: begin
          if (dly_q == DLW'(LOCK_DLY_CYC - 1)) st_q <= ST_ARM;
          else dly_q <= dly_q + 1'b1;
        end
        ST_ARM: begin
          if (count_vld_i) begin
            ref_q <= count_i;
            st_q  <= ST_TRACK;
          end
        end
        default: ;
      endcase
    end
  end

  // one-deep hold; a newer count replaces an older one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_vld_q <= 1'b0;
      hold_q     <= '0;
    end else if (tog || st_q != ST_TRACK) begin
      hold_vld_q <= 1'b0;
    end else if (count_vld_i && (busy_i || hold_vld_q)) begin
      hold_vld_q <= 1'b1;
      hold_q     <= count_i;
    end else if (go_o) begin
      hold_vld_q <= 1'b0;
    end
  end
endmodule

// File: rtl/err_quant.sv
`timescale 1ns/1ps
module err_quant
  import freq_lock_pkg::*;
#(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned STEP  = 10
) (
  input  logic [CNT_W-1:0] ref_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             up_o,
  output logic             nz_o,
  output logic [LVL_W-1:0] lvl_o
);
  logic [CNT_W-1:0]   mag;
  logic [LVL_SAT-1:0] ge;

  assign up_o = val_i < ref_i;
  assign mag  = up_o ? (ref_i - val_i) : (val_i - ref_i);
  assign nz_o = mag != '0;

  // thermometer of step thresholds; its popcount is the saturated level
  for (genvar k = 0; k < LVL_SAT; k++) begin : g_thr
    assign ge[k] = mag >= CNT_W'((k + 1) * STEP);
  end

  always_comb begin
    lvl_o = '0;
    for (int k = 0; k < LVL_SAT; k++) lvl_o = lvl_o + LVL_W'(ge[k]);
  end
endmodule

// File: rtl/corr_pulse.sv
`timescale 1ns/1ps
module corr_pulse
  import freq_lock_pkg::*;
#(
  parameter int unsigned MIN_W  = 3,
  parameter int unsigned STEP_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic             clr_i,
  input  logic             up_i,
  input  logic             nz_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic             up_o,
  output logic             down_o,
  output logic             busy_o,
  output logic [LVL_W-1:0] lvl_o,
  output logic             dir_o
);
  localparam int unsigned PW_MAX = MIN_W + LVL_SAT * STEP_W;
  localparam int unsigned PW_W   = $clog2(PW_MAX + 1);

  logic [PW_W-1:0]  pcnt_q, load;
  logic [LVL_W-1:0] lvl_q;
  logic             dir_q;

  assign load   = PW_W'(MIN_W) + PW_W'(lvl_i) * PW_W'(STEP_W);
  assign busy_o = pcnt_q != '0;
  assign up_o   = busy_o && dir_q;
  assign down_o = busy_o && !dir_q;
  assign lvl_o  = lvl_q;
  assign dir_o  = dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
      lvl_q  <= '0;
      dir_q  <= 1'b0;
    end else begin
      if (pcnt_q != '0) pcnt_q <= pcnt_q - 1'b1;
      if (go_i) begin
        lvl_q <= lvl_i;
        if (nz_i) begin
          pcnt_q <= load;
          dir_q  <= up_i;
        end
      end else if (clr_i) begin
        lvl_q <= '0;
      end
    end
  end
endmodule

// File: rtl/freq_lock_ctrl.sv
`timescale 1ns/1ps
module freq_lock_ctrl
  import freq_lock_pkg::*;
#(
  parameter int unsigned CNT_W        = 24,
  parameter int unsigned STEP         = 10,
  parameter int unsigned MIN_W        = 3,
  parameter int unsigned STEP_W       = 2,
  parameter int unsigned LOCK_DLY_CYC = 20,
  parameter int unsigned DEB_CYC      = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             btn_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             count_vld_i,
  output logic             locked_o,
  output logic             center_o,
  output logic             up_o,
  output logic             down_o,
  output logic [3:0]       err_lvl_o,
  output logic             dir_up_o
);
  lock_st_e         st;
  logic             press, busy, go, drop, e_up, e_nz;
  logic [CNT_W-1:0] val, ref_cnt;
  logic [LVL_W-1:0] e_lvl, lvl;

  btn_filter #(.DEB_CYC(DEB_CYC)) u_btn (
    .clk_i, .rst_ni, .raw_i(btn_i), .rise_o(press)
  );

  lock_seq #(.CNT_W(CNT_W), .LOCK_DLY_CYC(LOCK_DLY_CYC)) u_seq (
    .clk_i, .rst_ni, .press_i(press), .busy_i(busy),
    .count_i, .count_vld_i, .st_o(st), .go_o(go), .drop_o(drop),
    .val_o(val), .ref_o(ref_cnt)
  );

  err_quant #(.CNT_W(CNT_W), .STEP(STEP)) u_err (
    .ref_i(ref_cnt), .val_i(val), .up_o(e_up), .nz_o(e_nz), .lvl_o(e_lvl)
  );

  corr_pulse #(.MIN_W(MIN_W), .STEP_W(STEP_W)) u_pulse (
    .clk_i, .rst_ni, .go_i(go), .clr_i(drop), .up_i(e_up), .nz_i(e_nz),
    .lvl_i(e_lvl), .up_o, .down_o, .busy_o(busy), .lvl_o(lvl),
    .dir_o(dir_up_o)
  );

  assign locked_o  = st != ST_FREE;
  assign center_o  = st != ST_TRACK;
  assign err_lvl_o = 4'(lvl);
endmodule

// File: rtl/freq_lock_ctrl_chk.sv
`timescale 1ns/1ps
module freq_lock_ctrl_chk #(
  parameter int unsigned MIN_W = 3
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       locked_o,
  input logic       center_o,
  input logic       up_o,
  input logic       down_o,
  input logic [3:0] err_lvl_o,
  input logic       dir_up_o
);
  logic [15:0] run_q;
  logic        act;

  assign act = up_o || down_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else if (act) run_q <= (run_q == 16'hFFFF) ? run_q : run_q + 1'b1;
    else run_q <= '0;
  end

  // R8
  center_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    center_o |-> !act);
  // R3
  free_center_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_o |-> center_o);
  // R4
  one_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_o && down_o));
  // R9
  up_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_o |=> !down_o);
  // R9
  down_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    down_o |=> !up_o);
  // R6
  lvl_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_lvl_o <= 4'd9);
  // R7
  dir_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(up_o) |-> dir_up_o);
  // R7
  dir_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(down_o) |-> !dir_up_o);
  // R5
  min_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q != '0 && !act) |-> (run_q >= 16'(MIN_W)));
  // R10
  unlock_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_o) |-> !$past(act));
  // R11
  unlock_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_o) |-> err_lvl_o == 4'd0);
endmodule

bind freq_lock_ctrl freq_lock_ctrl_chk #(.MIN_W(MIN_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .locked_o(locked_o), .center_o(center_o),
  .up_o(up_o), .down_o(down_o), .err_lvl_o(err_lvl_o), .dir_up_o(dir_up_o)
);

// File: tb/freq_lock_ctrl_bench.sv
`timescale 1ns/1ps
module freq_lock_ctrl_bench;
  localparam int CNT_W = 24, STEP = 10, MIN_W = 3, STEP_W = 2;
  localparam int DLY = 20, DEB = 4;

  logic             clk = 1'b0, rst_n = 1'b0, btn = 1'b0, vld = 1'b0;
  logic [CNT_W-1:0] cnt = '0;
  logic             locked_o, center_o, up_o, down_o, dir_up_o;
  logic [3:0]       err_lvl_o;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  freq_lock_ctrl #(.CNT_W(CNT_W), .STEP(STEP), .MIN_W(MIN_W), .STEP_W(STEP_W),
                   .LOCK_DLY_CYC(DLY), .DEB_CYC(DEB)) u_freq_lock_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .btn_i(btn), .count_i(cnt),
    .count_vld_i(vld), .locked_o, .center_o, .up_o, .down_o,
    .err_lvl_o, .dir_up_o
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model: 0 free, 1 wait, 2 arm, 3 track
  int m_s1, m_s2, m_stab, m_dc, m_pend, m_st, m_dly, m_ref, m_hv, m_hval;
  int m_pcnt, m_dir, m_lvl;
  int t_rise, t_busy, t_pevt, t_tog, t_go, t_val, t_e, t_l;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_stab = 0; m_dc = 0; m_pend = 0; m_st = 0;
      m_dly = 0; m_ref = 0; m_hv = 0; m_hval = 0; m_pcnt = 0; m_dir = 0; m_lvl = 0;
    end else begin
      t_rise = (m_s2 != m_stab && m_dc == DEB - 1 && m_s2 == 1) ? 1 : 0;
      t_busy = m_pcnt > 0 ? 1 : 0;
      t_pevt = t_rise | m_pend;
      t_tog  = t_pevt & ~t_busy & 1;
      t_go   = (m_st == 3 && !t_busy && !t_pevt && (m_hv || vld)) ? 1 : 0;
      t_val  = m_hv ? m_hval : int'(cnt);
      // pulse and level
      if (m_pcnt > 0) m_pcnt--;
      if (t_go) begin
        t_e = t_val < m_ref ? m_ref - t_val : t_val - m_ref;
        t_l = t_e / STEP; if (t_l > 9) t_l = 9;
        m_lvl = t_l;
        if (t_e != 0) begin m_pcnt = MIN_W + t_l * STEP_W; m_dir = t_val < m_ref; end
      end else if (t_tog && m_st != 0) m_lvl = 0;
      // hold
      if (t_tog || m_st != 3) m_hv = 0;
      else if (vld && (t_busy || m_hv)) begin m_hv = 1; m_hval = int'(cnt); end
      else if (t_go) m_hv = 0;
      // state
      if (t_tog) begin
        if (m_st == 0) begin m_st = 1; m_dly = 0; end else m_st = 0;
      end else if (m_st == 1) begin
        if (m_dly == DLY - 1) m_st = 2; else m_dly++;
      end else if (m_st == 2 && vld) begin
        m_ref = int'(cnt); m_st = 3;
      end
      if (t_pevt && t_busy) m_pend = 1; else if (t_tog) m_pend = 0;
      // button filter
      if (m_s2 == m_stab) m_dc = 0;
      else if (m_dc == DEB - 1) begin m_stab = m_s2; m_dc = 0; end
      else m_dc++;
      m_s2 = m_s1; m_s1 = btn;
    end
  end

  // per-cycle comparison and pulse monitor
  int run = 0, last_len = 0, starts = 0;
  bit prev_act = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(locked_o == (m_st != 0), "R2 locked_o", locked_o, m_st != 0);
      check(center_o == (m_st != 3), "R8 center_o", center_o, m_st != 3);
      check(up_o == (m_pcnt > 0 && m_dir == 1), "R4 up_o", up_o, m_pcnt > 0 && m_dir == 1);
      check(down_o == (m_pcnt > 0 && m_dir == 0), "R4 down_o", down_o, m_pcnt > 0 && m_dir == 0);
      check(int'(err_lvl_o) == m_lvl, "R6 err_lvl_o", err_lvl_o, m_lvl);
      check(int'(dir_up_o) == m_dir, "R7 dir_up_o", dir_up_o, m_dir);
      if (up_o || down_o) begin
        run++;
        if (!prev_act) starts++;
      end else if (run > 0) begin
        last_len = run; run = 0;
      end
      prev_act = up_o || down_o;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic send(input int v);
    cnt = CNT_W'(v); vld = 1'b1;
    cyc(1);
    vld = 1'b0;
  endtask

  task automatic press();
    btn = 1'b1; cyc(DEB + 4);
    btn = 1'b0; cyc(DEB + 4);
  endtask

  int s0;

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1
    check(locked_o == 0 && center_o == 1, "R1 state", {locked_o, center_o}, 1);
    check(!up_o && !down_o && err_lvl_o == 0 && !dir_up_o, "R1 outputs",
          {up_o, down_o, err_lvl_o, dir_up_o}, 0);
    // R2 glitch shorter than filter
    btn = 1'b1; cyc(2); btn = 1'b0; cyc(10);
    check(locked_o == 0, "R2 glitch", locked_o, 0);
    // R3 lock, settle window ignores counts
    press();
    check(locked_o == 1, "R2 press", locked_o, 1);
    send(1000);
    check(center_o == 1, "R3 wait", center_o, 1);
    cyc(DLY + 2);
    send(5000);
    cyc(1);
    check(center_o == 0, "R3 captured", center_o, 1'b0);
    // R4 equal count
    s0 = starts;
    send(5000); cyc(10);
    check(starts == s0, "R4 equal no pulse", starts, s0);
    check(err_lvl_o == 0, "R4 equal level", err_lvl_o, 0);
    // R5 minimum pulse
    send(4997); cyc(30);
    check(last_len == MIN_W, "R5 min width", last_len, MIN_W);
    check(dir_up_o == 1, "R7 up", dir_up_o, 1);
    // R5 two steps above
    send(5025); cyc(30);
    check(last_len == MIN_W + 2 * STEP_W, "R5 two steps", last_len, MIN_W + 2 * STEP_W);
    check(err_lvl_o == 2 && dir_up_o == 0, "R6 level 2 down", err_lvl_o, 2);
    // R6 saturation
    send(4000); cyc(30);
    check(err_lvl_o == 9, "R6 saturate", err_lvl_o, 9);
    check(last_len == MIN_W + 9 * STEP_W, "R5 saturated width", last_len, MIN_W + 9 * STEP_W);
    // R9 counts during pulse: later one kept
    s0 = starts;
    send(5089); cyc(2); send(4990); send(4950); cyc(50);
    check(starts == s0 + 2, "R9 one pulse per kept count", starts, s0 + 2);
    check(err_lvl_o == 5 && dir_up_o == 1, "R9 held count used", err_lvl_o, 5);
    check(last_len == MIN_W + 5 * STEP_W, "R9 held width", last_len, MIN_W + 5 * STEP_W);
    // R10 press during pulse deferred
    send(4000); cyc(2);
    press(); cyc(20);
    check(last_len == MIN_W + 9 * STEP_W, "R10 pulse not cut", last_len, MIN_W + 9 * STEP_W);
    check(locked_o == 0, "R10 unlocked after pulse", locked_o, 0);
    // R11
    check(err_lvl_o == 0, "R11 level cleared", err_lvl_o, 0);
    // relock at new reference, then unlock while idle
    press(); cyc(DLY + 2); send(7000); cyc(2);
    s0 = starts;
    send(7000); cyc(5);
    check(starts == s0 && center_o == 0, "R3 new reference", starts, s0);
    send(7031); cyc(2); press(); cyc(10);
    check(locked_o == 0 && center_o == 1, "R8 neutral after unlock", center_o, 1);
    check(err_lvl_o == 0, "R11 cleared again", err_lvl_o, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog R1..: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule